// File: doc/BRIEF.md
# Address Range Breakpoint Unit

This block watches two memory access streams, a program stream and a data stream, and raises a debug request when an access falls inside a programmable inclusive address window. Each stream has its own section. A section holds a lower limit, an upper limit, an occurrence countdown and a latch that captures the access address. An access counts only when it comes from the selected source slot and is of an enabled kind (read, write or both). The countdown lets the request fire on the Nth qualifying access instead of the first one.

A shared control/status word holds the per-section enable and source-select fields and a trace enable. It also holds four sticky flags that record why the last debug request was raised. An instruction step counter requests debug entry after a programmed number of executed instructions, and a software debug strobe can request entry directly. Every request cause leads to the same registered one-cycle `debug_req` pulse. Software programs the unit through a small register strobe interface with combinational read data.

Top module: `addr_window_bkpt`

## Requirements
- R1: A latched access is in the window when its address is at or above the lower limit and at or below the upper limit. Both limits are inclusive. An address one below the lower limit or one above the upper limit neither counts nor fires.
- R2: A qualifying in-window access decrements the section's countdown when the countdown is nonzero. When the countdown is already zero, the access fires the section and the countdown stays at zero. A countdown loaded with N therefore fires on access N+1.
- R3: The 2-bit enable field selects which accesses qualify: 00 disables the section, 01 accepts writes only, 10 accepts reads only, and 11 accepts both. A non-qualifying access leaves the countdown unchanged.
- R4: A section latches an access only when the access's 2-bit source code equals the section's source-select field. An access from another source is ignored.
- R5: `debug_req` is a registered pulse. For a window hit it is high in the second cycle after the access is presented. For a trace or software cause it is high in the cycle after the cause.
- R6: The control/status word (register 0) has this layout. Bits 1:0 hold the program enable and bits 3:2 the program source select. Bits 5:4 hold the data enable and bits 7:6 the data source select. Bit 8 is the trace enable. Bits 16, 17, 18 and 19 are the program-hit, data-hit, trace and software flags. All bits reset to zero. Only bits 8:0 can be written, and bits 15:9 and 31:20 always read as zero.
- R7: A flag is set when its cause fires, and it stays set until the control/status word is read. A read clears the flag after returning it. A cause that fires in the same cycle as the read leaves its flag set.
- R8: With trace enabled, each `insn_done` pulse decrements the step counter (register 7). The pulse that finds the counter at 1 or 0 fires, leaves the counter at zero and sets the trace flag. With trace disabled, `insn_done` has no effect.
- R9: The step counter resets to zero and is cleared in the cycle after any `debug_req` pulse.
- R10: The limit and countdown registers use these addresses: program lower 1, program upper 2, program countdown 3, data lower 4, data upper 5, data countdown 6. A register write takes effect at the next clock edge. A countdown write made in the same cycle as a decrement takes priority over the decrement.
- R11: A `sw_debug` pulse requests debug entry and sets the software flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of register 0 clears the flags) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pm_valid | input | 1 | Program access valid |
| pm_addr | input | 32 | Program access address |
| pm_rd | input | 1 | Program access is a read |
| pm_wr | input | 1 | Program access is a write |
| pm_src | input | 2 | Program access source slot code |
| dm_valid | input | 1 | Data access valid |
| dm_addr | input | 32 | Data access address |
| dm_rd | input | 1 | Data access is a read |
| dm_wr | input | 1 | Data access is a write |
| dm_src | input | 2 | Data access source slot code |
| insn_done | input | 1 | One instruction completed |
| sw_debug | input | 1 | Software debug request |
| debug_req | output | 1 | Debug entry request pulse |

## Verification
The bench probes addresses one below and one above each window limit, and also uses a window one address wide. A comparator with a strict bound, or one that swaps its operands, would lose a boundary hit or gain a spurious one. The bench counts accesses against a loaded countdown, so a design that fires when the count reaches zero, instead of on the following access, would request one access early. It crosses the read/write enable code with read and write accesses and offers accesses from the wrong source slot; a design with a swapped enable bit or an unchecked source would fire where it must stay silent. It also lines up a countdown write with a pending decrement, and a software request with a status read, so that a design that lets the decrement win or lets the read clear the new flag shows a wrong count or a lost flag.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int DW = 32;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_TCNT = 3'd7;

    // control bit positions (fixed layout decoded by the debugger)
    localparam int CB_TEN   = 8;
    localparam int CB_WIDTH = 9;
    localparam int SB_BASE  = 16;
    localparam int NFLAG    = 4;

    // flag index within the sticky field
    localparam int FL_PROG = 0;
    localparam int FL_DATA = 1;
    localparam int FL_TRC  = 2;
    localparam int FL_SW   = 3;

    localparam int NCH = 2;
endpackage

// File: rtl/bkpt_window.sv
module bkpt_window #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             en,
    input  logic [1:0]             sel,
    input  logic                   acc_valid,
    input  logic [AW-1:0]          acc_addr,
    input  logic                   acc_rd,
    input  logic                   acc_wr,
    input  logic [1:0]             acc_src,
    input  logic                   wr_lo,
    input  logic                   wr_hi,
    input  logic                   wr_cnt,
    input  logic [bkpt_pkg::DW-1:0] wdata,
    output logic [AW-1:0]          lo,
    output logic [AW-1:0]          hi,
    output logic [CW-1:0]          cnt,
    output logic                   fire
);
    typedef struct packed {
        logic          lat_vld;
        logic          lat_rd;
        logic          lat_wr;
        logic [AW-1:0] lat_addr;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
        logic [CW-1:0] cnt;
    } win_st_t;

    win_st_t s_d, s_q;
    logic above_lo, below_hi, kind_ok, hit;

    always_comb begin
        s_d = s_q;
        // stage 1: capture the access of the selected slot
        s_d.lat_vld = acc_valid && (acc_src == sel);
        if (s_d.lat_vld) begin
            s_d.lat_addr = acc_addr;
            s_d.lat_rd   = acc_rd;
            s_d.lat_wr   = acc_wr;
        end
        // stage 2: compare the latched access
        above_lo = (s_q.lat_addr >= s_q.lo);
        below_hi = (s_q.lat_addr <= s_q.hi);
        kind_ok  = (en[0] && s_q.lat_wr) || (en[1] && s_q.lat_rd);
        hit      = s_q.lat_vld && above_lo && below_hi && kind_ok;
        fire     = hit && (s_q.cnt == '0);
        if (hit && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        // register writes take priority
        if (wr_lo)  s_d.lo  = wdata[AW-1:0];
        if (wr_hi)  s_d.hi  = wdata[AW-1:0];
        if (wr_cnt) s_d.cnt = wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lo  = s_q.lo;
    assign hi  = s_q.hi;
    assign cnt = s_q.cnt;

    // R2: without a write the countdown never rises
    p_cnt_no_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_cnt) |-> (s_q.cnt <= $past(s_q.cnt)));

    // R2: after firing the countdown remains at zero
    p_zero_after_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_cnt) |=> (s_q.cnt == '0));

    // R3: a disabled section never fires
    p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 2'b00) |-> !fire);

    // R4: a latched access always came from the selected slot
    p_slot_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_d.lat_vld |-> (acc_valid && acc_src == sel));
endmodule

// File: rtl/bkpt_trace.sv
module bkpt_trace #(
    parameter int CW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    insn_done,
    input  logic                    entry,
    input  logic                    wr,
    input  logic [bkpt_pkg::DW-1:0] wdata,
    output logic [CW-1:0]           cnt,
    output logic                    fire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } trc_st_t;

    trc_st_t s_d, s_q;
    logic    step;

    always_comb begin
        s_d  = s_q;
        step = enable && insn_done;
        fire = step && (s_q.cnt <= CW'(1));
        if (wr) begin
            s_d.cnt = wdata[CW-1:0];
        end else if (entry) begin
            s_d.cnt = '0;
        end else if (step) begin
            s_d.cnt = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

    // R9: a debug entry clears the step counter unless software writes it
    p_entry_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && !wr) |=> (s_q.cnt == '0));

    // R8: without a step or write the counter holds or clears
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr && !entry) |=> $stable(s_q.cnt));
endmodule

// File: rtl/addr_window_bkpt.sv
module addr_window_bkpt #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          pm_valid,
    input  logic [AW-1:0] pm_addr,
    input  logic          pm_rd,
    input  logic          pm_wr,
    input  logic [1:0]    pm_src,
    input  logic          dm_valid,
    input  logic [AW-1:0] dm_addr,
    input  logic          dm_rd,
    input  logic          dm_wr,
    input  logic [1:0]    dm_src,
    input  logic          insn_done,
    input  logic          sw_debug,
    output logic          debug_req
);
    import bkpt_pkg::*;

    localparam int RSTRIDE = 3;

    typedef struct packed {
        logic [CB_WIDTH-1:0] ctrl;
        logic [NFLAG-1:0]    flags;
        logic                req;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [NCH-1:0]         ch_valid, ch_rd, ch_wr, ch_fire;
    logic [NCH-1:0][AW-1:0] ch_addr, ch_lo, ch_hi;
    logic [NCH-1:0][1:0]    ch_src;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0]         wr_lo, wr_hi, wr_cnt;
    logic [CW-1:0]          tcnt;
    logic                   t_fire, stat_rd;
    logic [NFLAG-1:0]       events;

    assign ch_valid = {dm_valid, pm_valid};
    assign ch_rd    = {dm_rd, pm_rd};
    assign ch_wr    = {dm_wr, pm_wr};
    assign ch_addr  = {dm_addr, pm_addr};
    assign ch_src   = {dm_src, pm_src};

    for (genvar g = 0; g < NCH; g++) begin : g_win
        localparam logic [2:0] BASE = 3'(1 + RSTRIDE * g);
        assign wr_lo[g]  = reg_wr && (reg_addr == BASE);
        assign wr_hi[g]  = reg_wr && (reg_addr == BASE + 3'd1);
        assign wr_cnt[g] = reg_wr && (reg_addr == BASE + 3'd2);

        bkpt_window #(.AW(AW), .CW(CW)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (s_q.ctrl[4*g +: 2]),
            .sel       (s_q.ctrl[4*g+2 +: 2]),
            .acc_valid (ch_valid[g]),
            .acc_addr  (ch_addr[g]),
            .acc_rd    (ch_rd[g]),
            .acc_wr    (ch_wr[g]),
            .acc_src   (ch_src[g]),
            .wr_lo     (wr_lo[g]),
            .wr_hi     (wr_hi[g]),
            .wr_cnt    (wr_cnt[g]),
            .wdata     (reg_wdata),
            .lo        (ch_lo[g]),
            .hi        (ch_hi[g]),
            .cnt       (ch_cnt[g]),
            .fire      (ch_fire[g])
        );
    end

    bkpt_trace #(.CW(CW)) u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (s_q.ctrl[CB_TEN]),
        .insn_done (insn_done),
        .entry     (s_q.req),
        .wr        (reg_wr && (reg_addr == RA_TCNT)),
        .wdata     (reg_wdata),
        .cnt       (tcnt),
        .fire      (t_fire)
    );

    always_comb begin
        s_d     = s_q;
        stat_rd = reg_rd && (reg_addr == RA_CTRL);
        events  = '0;
        events[FL_PROG] = ch_fire[0];
        events[FL_DATA] = ch_fire[1];
        events[FL_TRC]  = t_fire;
        events[FL_SW]   = sw_debug;

        s_d.flags = (stat_rd ? '0 : s_q.flags) | events;
        s_d.req   = |events;
        if (reg_wr && (reg_addr == RA_CTRL)) begin
            s_d.ctrl = reg_wdata[CB_WIDTH-1:0];
        end

        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_WIDTH-1:0]          = s_q.ctrl;
                reg_rdata[SB_BASE +: NFLAG]      = s_q.flags;
            end
            3'd1: reg_rdata[AW-1:0] = ch_lo[0];
            3'd2: reg_rdata[AW-1:0] = ch_hi[0];
            3'd3: reg_rdata[CW-1:0] = ch_cnt[0];
            3'd4: reg_rdata[AW-1:0] = ch_lo[1];
            3'd5: reg_rdata[AW-1:0] = ch_hi[1];
            3'd6: reg_rdata[CW-1:0] = ch_cnt[1];
            default: reg_rdata[CW-1:0] = tcnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign debug_req = s_q.req;

    // R7: flags persist until a status read
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_rd) |-> ((s_q.flags & $past(s_q.flags)) == $past(s_q.flags)));

    // R6: reserved status bits read as zero
    p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_CTRL) |-> (reg_rdata[15:9] == '0 && reg_rdata[31:20] == '0));

    // R5: a request pulse is always accompanied by a new flag bit
    p_req_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        debug_req |-> (s_q.flags != '0));

    // R11: a software strobe always produces a request next cycle
    p_sw_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_debug |=> debug_req);
endmodule

// File: tb/sim_addr_window_bkpt.sv
`timescale 1ns/1ps
module sim_addr_window_bkpt;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        pm_valid = 0, pm_rd = 0, pm_wr = 0;
    logic [31:0] pm_addr = 0;
    logic [1:0]  pm_src = 0;
    logic        dm_valid = 0, dm_rd = 0, dm_wr = 0;
    logic [31:0] dm_addr = 0;
    logic [1:0]  dm_src = 0;
    logic        insn_done = 0, sw_debug = 0;
    logic        debug_req;

    addr_window_bkpt u0 (.*);

    always #5 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    int exp_q[$];
    logic [31:0] m_lo[2], m_hi[2], m_cnt[2];
    logic [1:0]  m_en[2], m_sel[2];
    logic        m_ten = 0;
    logic [31:0] m_tcnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare request pulses with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                nchk++;
                if (debug_req !== 1'b1) begin
                    nerr++;
                    $display("FAIL R5 debug_req at cycle %0d: got %b expected 1", cyc, debug_req);
                end
                void'(exp_q.pop_front());
            end else if (debug_req !== 1'b0) begin
                nchk++;
                nerr++;
                $display("FAIL R5 unexpected debug_req at cycle %0d: got %b expected 0", cyc, debug_req);
            end
        end
    end

    task automatic expect_req(input int at);
        exp_q.push_back(at);
        m_tcnt = 0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        for (int c = 0; c < 2; c++) begin
            m_en[c]  = v[4*c +: 2];
            m_sel[c] = v[4*c+2 +: 2];
        end
        m_ten = v[8];
        wr_reg(3'd0, v);
    endtask

    task automatic set_win(input int ch, input logic [31:0] lo, input logic [31:0] hi,
                           input logic [31:0] cnt);
        m_lo[ch] = lo; m_hi[ch] = hi; m_cnt[ch] = cnt;
        wr_reg(3'(1 + 3*ch), lo);
        wr_reg(3'(2 + 3*ch), hi);
        wr_reg(3'(3 + 3*ch), cnt);
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] mask,
                           input logic [31:0] expv, input string tag);
        reg_rd = 1; reg_addr = a;
        #1;
        nchk++;
        if ((reg_rdata & mask) !== expv) begin
            nerr++;
            $display("FAIL %s reg %0d: got %h expected %h", tag, a, reg_rdata & mask, expv);
        end
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic acc(input int ch, input logic [31:0] a, input logic r, input logic w,
                       input logic [1:0] src);
        bit hit;
        if (ch == 0) begin
            pm_valid = 1; pm_addr = a; pm_rd = r; pm_wr = w; pm_src = src;
        end else begin
            dm_valid = 1; dm_addr = a; dm_rd = r; dm_wr = w; dm_src = src;
        end
        hit = (src == m_sel[ch]) && (a >= m_lo[ch]) && (a <= m_hi[ch]) &&
              ((m_en[ch][0] && w) || (m_en[ch][1] && r));
        if (hit) begin
            if (m_cnt[ch] == 0) expect_req(cyc + 2);
            else m_cnt[ch] = m_cnt[ch] - 1;
        end
        @(negedge clk);
        pm_valid = 0; dm_valid = 0;
    endtask

    task automatic step();
        insn_done = 1;
        if (m_ten) begin
            if (m_tcnt <= 1) expect_req(cyc + 1);
            else m_tcnt = m_tcnt - 1;
        end
        @(negedge clk);
        insn_done = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_cnt[c] = 0; m_en[c] = 0; m_sel[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle(1);
        // R6 R9 reset state
        chk_reg(3'd0, 32'hFFFF_FFFF, 32'h0, "R6 reset ctrl");
        chk_reg(3'd3, 32'hFFFF_FFFF, 32'h0, "R2 reset count");
        chk_reg(3'd7, 32'hFFFF_FFFF, 32'h0, "R9 reset step counter");

        // R1 R2 program window, countdown 2
        set_win(0, 32'h100, 32'h1FF, 32'd2);
        set_ctrl(32'h003);
        acc(0, 32'h0FF, 1, 0, 2'd0);
        acc(0, 32'h200, 1, 0, 2'd0);
        idle(2);
        chk_reg(3'd3, 32'hFFFF_FFFF, 32'd2, "R1 outside limits ignored");
        acc(0, 32'h100, 1, 0, 2'd0);
        acc(0, 32'h1FF, 1, 0, 2'd0);
        idle(2);
        chk_reg(3'd3, 32'hFFFF_FFFF, 32'd0, "R2 inclusive hits decrement");
        acc(0, 32'h150, 1, 0, 2'd0);   // R2 third access fires
        idle(3);
        chk_reg(3'd0, 32'h0001_0000, 32'h0001_0000, "R7 program flag set");
        chk_reg(3'd0, 32'h0001_0000, 32'h0, "R7 flag cleared by read");

        // R3 enable codes
        set_ctrl(32'h001);
        acc(0, 32'h120, 1, 0, 2'd0);
        acc(0, 32'h120, 0, 1, 2'd0);
        idle(3);
        set_ctrl(32'h002);
        acc(0, 32'h120, 0, 1, 2'd0);
        acc(0, 32'h120, 1, 0, 2'd0);
        idle(3);
        set_win(0, 32'h100, 32'h1FF, 32'd1);
        set_ctrl(32'h000);
        acc(0, 32'h120, 1, 1, 2'd0);
        idle(3);
        chk_reg(3'd3, 32'hFFFF_FFFF, 32'd1, "R3 disabled leaves count");

        // R4 source select
        set_win(0, 32'h100, 32'h1FF, 32'd0);
        set_ctrl(32'h00B);
        acc(0, 32'h130, 1, 0, 2'd0);
        acc(0, 32'h130, 1, 0, 2'd3);
        idle(3);
        acc(0, 32'h130, 1, 0, 2'd2);
        idle(3);

        // R10 write beats a same-cycle decrement
        set_win(0, 32'h100, 32'h1FF, 32'd5);
        pm_valid = 1; pm_addr = 32'h140; pm_rd = 1; pm_wr = 0; pm_src = 2'd2;
        @(negedge clk);
        pm_valid = 0;
        m_cnt[0] = 32'd7;
        wr_reg(3'd3, 32'd7);
        idle(2);
        chk_reg(3'd3, 32'hFFFF_FFFF, 32'd7, "R10 write wins over decrement");
        chk_reg(3'd2, 32'hFFFF_FFFF, 32'h1FF, "R10 upper limit readback");

        // R1 single-address data window, R2 countdown 1
        set_ctrl(32'h000);
        chk_reg(3'd0, 32'h0, 32'h0, "R7 flush flags");
        set_win(1, 32'h8000, 32'h8000, 32'd1);
        set_ctrl(32'h0A0);
        acc(1, 32'h8001, 1, 0, 2'd2);
        acc(1, 32'h7FFF, 1, 0, 2'd2);
        acc(1, 32'h8000, 1, 0, 2'd2);
        acc(1, 32'h8000, 1, 0, 2'd2);
        idle(3);
        chk_reg(3'd0, 32'h000F_0000, 32'h0002_0000, "R7 data flag only");

        // R8 trace stepping
        set_ctrl(32'h000);
        m_tcnt = 32'd3;
        wr_reg(3'd7, 32'd3);
        step();
        idle(2);
        chk_reg(3'd7, 32'hFFFF_FFFF, 32'd3, "R8 trace disabled holds");
        set_ctrl(32'h100);
        step(); step(); step();
        idle(3);
        chk_reg(3'd7, 32'hFFFF_FFFF, 32'd0, "R8 counter at zero");
        chk_reg(3'd0, 32'h000F_0000, 32'h0004_0000, "R8 trace flag");

        // R9 R11 software request clears the step counter
        set_ctrl(32'h000);
        m_tcnt = 32'd5;
        wr_reg(3'd7, 32'd5);
        sw_debug = 1;
        expect_req(cyc + 1);
        @(negedge clk);
        sw_debug = 0;
        idle(2);
        chk_reg(3'd7, 32'hFFFF_FFFF, 32'd0, "R9 entry clears step counter");
        chk_reg(3'd0, 32'h000F_0000, 32'h0008_0000, "R11 software flag");

        // R7 set during a status read survives
        sw_debug = 1; reg_rd = 1; reg_addr = 3'd0;
        expect_req(cyc + 1);
        #1;
        nchk++;
        if (reg_rdata[19] !== 1'b0) begin
            nerr++;
            $display("FAIL R7 flag before event: got %b expected 0", reg_rdata[19]);
        end
        @(negedge clk);
        sw_debug = 0; reg_rd = 0;
        idle(1);
        chk_reg(3'd0, 32'h0008_0000, 32'h0008_0000, "R7 set wins over clear");

        // R6 only control bits writable
        wr_reg(3'd0, 32'hFFFF_FFFF);
        chk_reg(3'd0, 32'hFFFF_FFFF, 32'h0000_01FF, "R6 reserved read zero");
        set_ctrl(32'h000);
        idle(3);

        nchk++;
        if (exp_q.size() != 0) begin
            nerr++;
            $display("FAIL R5 missing requests: got %0d pending expected 0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule